// File: doc/BRIEF.md
# Multi-FIFO Interprocessor Mailbox

A memory-mapped mailbox in which several processors, called users, pass 32-bit messages to one another through a parameterised set of hardware FIFOs. A sender writes a word to a FIFO's message register and a receiver reads it back from the same offset. For each FIFO the bus can also read a full flag and a message count. Every FIFO reports two events: a message was accepted, and a pop took the FIFO out of the full condition. Each user has its own sticky status copy of all events, its own enable mask with separate set and clear registers, and its own interrupt line.

Each FIFO is controlled by a small state machine with three states. FS_EMPTY holds no data. FS_PART holds between one and DEPTH-1 words. FS_FULL holds DEPTH words. An accepted push moves FS_EMPTY to FS_PART (or to FS_FULL when DEPTH is 1). A push that fills the last slot moves FS_PART to FS_FULL. A pop moves FS_FULL to FS_PART. A pop of the last word moves FS_PART to FS_EMPTY. Any other accepted traffic keeps FS_PART in FS_PART. Pops are ignored in FS_EMPTY and pushes are ignored in FS_FULL. The bus has a single address shared by reads and writes. Read data is registered.

Top module: `mbx_ctrl`

## Requirements
- R1: A read of offset 0x000 returns the REVISION parameter. Writes to 0x000 have no effect.
- R2: A write to 0x040+4*m pushes wr_data into FIFO m. A read of 0x040+4*m removes the oldest word of FIFO m and returns it. Words leave in the order they were accepted. Every read result appears on rd_data in the clock cycle after rd_en is sampled. rd_data is 0 in any cycle that follows no read.
- R3: A write to a FIFO that already holds DEPTH words is dropped. A read from an empty FIFO returns 0 and changes no state.
- R4: A read of 0x080+4*m returns 1 while FIFO m holds DEPTH words and 0 otherwise.
- R5: A read of 0x0C0+4*m returns the number of words in FIFO m, from 0 to DEPTH.
- R6: Every accepted push into FIFO m sets status bit 2*m of every user. User u's status register is at 0x104+0x10*u. Writing 1 to a status bit clears it and writing 0 leaves it unchanged. Clearing bit 2*m has no effect while FIFO m still holds data.
- R7: A pop from FIFO m while it holds DEPTH words sets status bit 2*m+1 of every user.
- R8: For user u, writing ones to 0x108+0x10*u sets those enable bits and writing ones to 0x10C+0x10*u clears only those enable bits. A read of either offset returns the enable mask.
- R9: irq[u] is high exactly when some bit is set in both the status register and the enable mask of user u.
- R10: Reads of unmapped offsets return 0, and writes to unmapped or read-only offsets have no effect. When wr_en and rd_en are high in the same cycle, only the write takes place and the following rd_data is 0.
- R11: After reset, all FIFOs are empty, all status and enable bits are 0, every irq is low and rd_data is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 12 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DW | Registered read data |
| irq | output | NUM_USERS | Interrupt line per user |

## Verification
The bench builds the block with three FIFOs, two users and a depth of four. With these values the top event bits (4 and 5) and the second user's register block at 0x114..0x11C can be reached. A FIFO fills to its full state in four writes, so overflow, the full-to-not-full event and the full flag are all reached in a short run. Having two users shows that one user's enable mask leaves the other user's interrupt unchanged, while both users see the same status events.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W      = 12;
    localparam int MSG_BASE    = 'h040;
    localparam int FULL_BASE   = 'h080;
    localparam int CNT_BASE    = 'h0C0;
    localparam int USR_BASE    = 'h104;
    localparam int USR_STRIDE  = 'h10;
    localparam int EN_SET_OFS  = 4;
    localparam int EN_CLR_OFS  = 8;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;

    function automatic logic [ADDR_W-1:0] msg_addr(input int m);
        return ADDR_W'(MSG_BASE + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] full_addr(input int m);
        return ADDR_W'(FULL_BASE + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] cnt_addr(input int m);
        return ADDR_W'(CNT_BASE + 4 * m);
    endfunction

    function automatic logic [ADDR_W-1:0] stat_addr(input int u);
        return ADDR_W'(USR_BASE + USR_STRIDE * u);
    endfunction

    function automatic logic [ADDR_W-1:0] enset_addr(input int u);
        return ADDR_W'(USR_BASE + USR_STRIDE * u + EN_SET_OFS);
    endfunction

    function automatic logic [ADDR_W-1:0] enclr_addr(input int u);
        return ADDR_W'(USR_BASE + USR_STRIDE * u + EN_CLR_OFS);
    endfunction
endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo
    import mbx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          push_ok,
    output logic          freed
);
    logic [DW-1:0] mem [DEPTH];
    fifo_state_e   st_q, st_d;
    logic [PW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // which requests the current state may accept
    always_comb begin : accept
        do_push = 1'b0;
        do_pop  = 1'b0;
        unique case (st_q)
            FS_EMPTY: do_push = push;
            FS_PART: begin
                do_push = push;
                do_pop  = pop;
            end
            FS_FULL:  do_pop = pop;
            default: ;
        endcase
    end

    always_comb cnt_d = cnt_q + CW'(do_push) - CW'(do_pop);

    always_comb begin : next_state
        st_d = st_q;
        unique case (st_q)
            FS_EMPTY: if (do_push) st_d = (cnt_d == CW'(DEPTH)) ? FS_FULL : FS_PART;
            FS_PART: begin
                if (cnt_d == '0)              st_d = FS_EMPTY;
                else if (cnt_d == CW'(DEPTH)) st_d = FS_FULL;
            end
            FS_FULL:  if (do_pop) st_d = (cnt_d == '0) ? FS_EMPTY : FS_PART;
            default:  st_d = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin : state_reg
        if (!rst_n) st_q <= FS_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin : ptr_reg
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= bump(wp_q);
            if (do_pop)  rp_q <= bump(rp_q);
            cnt_q <= cnt_d;
        end
    end

    always_ff @(posedge clk) begin : store
        if (do_push) mem[wp_q] <= din;
    end

    always_comb begin : outputs
        head    = (st_q == FS_EMPTY) ? '0 : mem[rp_q];
        level   = cnt_q;
        full    = (st_q == FS_FULL);
        push_ok = do_push;
        freed   = do_pop && (st_q == FS_FULL);
    end
endmodule

// File: rtl/mbx_regdec.sv
module mbx_regdec
    import mbx_pkg::*;
#(
    parameter int NUM_FIFOS = 4,
    parameter int NUM_USERS = 2
) (
    input  logic [ADDR_W-1:0]    addr,
    output logic                 sel_rev,
    output logic [NUM_FIFOS-1:0] sel_msg,
    output logic [NUM_FIFOS-1:0] sel_full,
    output logic [NUM_FIFOS-1:0] sel_cnt,
    output logic [NUM_USERS-1:0] sel_stat,
    output logic [NUM_USERS-1:0] sel_ens,
    output logic [NUM_USERS-1:0] sel_enc
);
    always_comb begin
        sel_rev = (addr == '0);
        for (int m = 0; m < NUM_FIFOS; m++) begin
            sel_msg[m]  = (addr == msg_addr(m));
            sel_full[m] = (addr == full_addr(m));
            sel_cnt[m]  = (addr == cnt_addr(m));
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            sel_stat[u] = (addr == stat_addr(u));
            sel_ens[u]  = (addr == enset_addr(u));
            sel_enc[u]  = (addr == enclr_addr(u));
        end
    end
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
    parameter int NUM_FIFOS = 4,
    localparam int IW       = 2 * NUM_FIFOS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FIFOS-1:0] arrived,
    input  logic [NUM_FIFOS-1:0] freed,
    input  logic [NUM_FIFOS-1:0] holding,
    input  logic                 stat_wr,
    input  logic                 en_set,
    input  logic                 en_clr,
    input  logic [IW-1:0]        wbits,
    output logic [IW-1:0]        status,
    output logic [IW-1:0]        enable,
    output logic                 irq
);
    logic [IW-1:0] evt, keep, w1c;

    always_comb begin
        for (int m = 0; m < NUM_FIFOS; m++) begin
            evt[2*m]    = arrived[m];
            evt[2*m+1]  = freed[m];
            keep[2*m]   = holding[m];
            keep[2*m+1] = 1'b0;
        end
        w1c = stat_wr ? wbits : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= evt | (status & ~(w1c & ~keep));
            if (en_set)      enable <= enable | wbits;
            else if (en_clr) enable <= enable & ~wbits;
        end
    end

    always_comb irq = |(status & enable);
endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
    import mbx_pkg::*;
#(
    parameter int          NUM_FIFOS = 4,
    parameter int          NUM_USERS = 2,
    parameter int          DEPTH     = 4,
    parameter int          DW        = 32,
    parameter logic [31:0] REVISION  = 32'h0001_0200
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr_en,
    input  logic [DW-1:0]        wr_data,
    input  logic                 rd_en,
    output logic [DW-1:0]        rd_data,
    output logic [NUM_USERS-1:0] irq
);
    localparam int IW = 2 * NUM_FIFOS;
    localparam int CW = $clog2(DEPTH + 1);

    logic                    rd_go;
    logic                    sel_rev;
    logic [NUM_FIFOS-1:0]    sel_msg, sel_full, sel_cnt;
    logic [NUM_USERS-1:0]    sel_stat, sel_ens, sel_enc;
    logic [DW-1:0]           head_arr [NUM_FIFOS];
    logic [NUM_FIFOS*CW-1:0] lvl_flat;
    logic [NUM_FIFOS-1:0]    full_v, arrived, freed, holding;
    logic [NUM_USERS*IW-1:0] stat_flat, en_flat;
    logic [DW-1:0]           rmux;

    assign rd_go = rd_en & ~wr_en;

    mbx_regdec #(.NUM_FIFOS(NUM_FIFOS), .NUM_USERS(NUM_USERS)) u_dec (
        .addr     (addr),
        .sel_rev  (sel_rev),
        .sel_msg  (sel_msg),
        .sel_full (sel_full),
        .sel_cnt  (sel_cnt),
        .sel_stat (sel_stat),
        .sel_ens  (sel_ens),
        .sel_enc  (sel_enc)
    );

    for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_fifo
        logic [CW-1:0] lvl;
        mbx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (wr_en & sel_msg[m]),
            .pop     (rd_go & sel_msg[m]),
            .din     (wr_data),
            .head    (head_arr[m]),
            .level   (lvl),
            .full    (full_v[m]),
            .push_ok (arrived[m]),
            .freed   (freed[m])
        );
        assign lvl_flat[m*CW +: CW] = lvl;
        assign holding[m]           = (lvl != '0);
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_user
        mbx_user_irq #(.NUM_FIFOS(NUM_FIFOS)) u_irq (
            .clk     (clk),
            .rst_n   (rst_n),
            .arrived (arrived),
            .freed   (freed),
            .holding (holding),
            .stat_wr (wr_en & sel_stat[u]),
            .en_set  (wr_en & sel_ens[u]),
            .en_clr  (wr_en & sel_enc[u]),
            .wbits   (wr_data[IW-1:0]),
            .status  (stat_flat[u*IW +: IW]),
            .enable  (en_flat[u*IW +: IW]),
            .irq     (irq[u])
        );
    end

    always_comb begin : read_mux
        rmux = '0;
        if (sel_rev) rmux = DW'(REVISION);
        for (int m = 0; m < NUM_FIFOS; m++) begin
            if (sel_msg[m])  rmux = head_arr[m];
            if (sel_full[m]) rmux = DW'(full_v[m]);
            if (sel_cnt[m])  rmux = DW'(lvl_flat[m*CW +: CW]);
        end
        for (int u = 0; u < NUM_USERS; u++) begin
            if (sel_stat[u])              rmux = DW'(stat_flat[u*IW +: IW]);
            if (sel_ens[u] || sel_enc[u]) rmux = DW'(en_flat[u*IW +: IW]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin : read_reg
        if (!rst_n) rd_data <= '0;
        else        rd_data <= rd_go ? rmux : '0;
    end
endmodule

// File: rtl/mbx_ctrl_chk.sv
module mbx_ctrl_chk
    import mbx_pkg::*;
#(
    parameter int          NUM_FIFOS = 4,
    parameter int          NUM_USERS = 2,
    parameter int          DEPTH     = 4,
    parameter int          DW        = 32,
    parameter logic [31:0] REVISION  = 32'h0001_0200,
    localparam int IW = 2 * NUM_FIFOS,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ADDR_W-1:0]       addr,
    input logic                    wr_en,
    input logic [DW-1:0]           wr_data,
    input logic                    rd_en,
    input logic [DW-1:0]           rd_data,
    input logic [NUM_USERS-1:0]    irq,
    input logic [NUM_FIFOS*CW-1:0] lvl_flat,
    input logic [NUM_USERS*IW-1:0] stat_flat
);
    // R1
    rev_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && addr == '0) |=> rd_data == DW'(REVISION));

    // R10
    dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en) |=> rd_data == '0);

    for (genvar m = 0; m < NUM_FIFOS; m++) begin : g_f
        logic [CW-1:0] lvl;
        assign lvl = lvl_flat[m*CW +: CW];

        // R3
        empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en && addr == msg_addr(m) && lvl == '0) |=> rd_data == '0);

        // R4
        full_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_en && !wr_en && addr == full_addr(m))
            |=> rd_data == DW'($past(lvl) == CW'(DEPTH)));

        // R5
        level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            lvl <= CW'(DEPTH));

        for (genvar u = 0; u < NUM_USERS; u++) begin : g_u
            // R7
            notfull_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (rd_en && !wr_en && addr == msg_addr(m) && lvl == CW'(DEPTH))
                |=> stat_flat[u*IW + 2*m + 1]);
        end
    end

    for (genvar u = 0; u < NUM_USERS; u++) begin : g_e
        // R8
        en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == enclr_addr(u) && wr_data[IW-1:0] == '1) |=> !irq[u]);
    end
endmodule

bind mbx_ctrl mbx_ctrl_chk #(
    .NUM_FIFOS (NUM_FIFOS),
    .NUM_USERS (NUM_USERS),
    .DEPTH     (DEPTH),
    .DW        (DW),
    .REVISION  (REVISION)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .irq       (irq),
    .lvl_flat  (lvl_flat),
    .stat_flat (stat_flat)
);

// File: tb/mbx_ctrl_bench.sv
module mbx_ctrl_bench;
    localparam int          NF    = 3;
    localparam int          NU    = 2;
    localparam int          DEPTH = 4;
    localparam logic [31:0] REV   = 32'h0001_0200;
    localparam logic        WR = 1'b0, RD = 1'b1;

    logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [11:0]   addr = '0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NU-1:0] irq;
    int            checks = 0, failures = 0;

    always #5 clk = ~clk;

    mbx_ctrl #(.NUM_FIFOS(NF), .NUM_USERS(NU), .DEPTH(DEPTH), .DW(32), .REVISION(REV)) u_mbx_ctrl (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .irq(irq)
    );

    // {requirement, op, offset, write data or expected read value}
    localparam int NV = 37;
    localparam logic [48:0] VEC [NV] = '{
        {4'd1,  RD, 12'h000, REV},          // R1 revision
        {4'd2,  WR, 12'h040, 32'h11},       // R2 pushes
        {4'd2,  WR, 12'h040, 32'h22},
        {4'd2,  WR, 12'h040, 32'h33},
        {4'd5,  RD, 12'h0C0, 32'd3},        // R5 level
        {4'd4,  RD, 12'h080, 32'd0},        // R4 not full
        {4'd2,  WR, 12'h040, 32'h44},
        {4'd4,  RD, 12'h080, 32'd1},        // R4 full
        {4'd3,  WR, 12'h040, 32'h55},       // R3 dropped
        {4'd5,  RD, 12'h0C0, 32'd4},
        {4'd2,  RD, 12'h040, 32'h11},       // R2 order
        {4'd4,  RD, 12'h080, 32'd0},
        {4'd2,  RD, 12'h040, 32'h22},
        {4'd2,  RD, 12'h040, 32'h33},
        {4'd3,  RD, 12'h040, 32'h44},       // R3 overflow word absent
        {4'd3,  RD, 12'h040, 32'h0},        // R3 empty read
        {4'd5,  RD, 12'h0C0, 32'd0},
        {4'd2,  WR, 12'h044, 32'hAA},
        {4'd5,  RD, 12'h0C4, 32'd1},
        {4'd5,  RD, 12'h0C8, 32'd0},
        {4'd6,  RD, 12'h104, 32'h7},        // R6 bits 0,2 and R7 bit 1
        {4'd7,  RD, 12'h114, 32'h7},        // R7 second user
        {4'd6,  WR, 12'h104, 32'h3},
        {4'd6,  RD, 12'h104, 32'h4},
        {4'd6,  WR, 12'h104, 32'h4},
        {4'd6,  RD, 12'h104, 32'h4},        // R6 held while FIFO 1 has data
        {4'd6,  RD, 12'h114, 32'h7},
        {4'd8,  WR, 12'h108, 32'h5},        // R8 set
        {4'd8,  RD, 12'h108, 32'h5},
        {4'd8,  WR, 12'h10C, 32'h1},        // R8 clear
        {4'd8,  RD, 12'h10C, 32'h4},
        {4'd8,  RD, 12'h118, 32'h0},
        {4'd1,  WR, 12'h000, 32'hDEAD},
        {4'd1,  RD, 12'h000, REV},
        {4'd10, RD, 12'h200, 32'h0},        // R10 unmapped
        {4'd10, WR, 12'h084, 32'h1},
        {4'd10, RD, 12'h084, 32'h0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rd_data;
        rd_en = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        logic [31:0] got;
        logic [3:0]  rq;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 irq after reset", 32'(irq), 32'h0);
        chk("R11 rd_data after reset", rd_data, 32'h0);
        rst_n = 1'b1;
        bus_rd(12'h104, got);
        chk("R11 status after reset", got, 32'h0);

        for (int i = 0; i < NV; i++) begin
            rq = VEC[i][48:45];
            if (VEC[i][44] == RD) begin
                bus_rd(VEC[i][43:32], got);
                chk($sformatf("R%0d vector %0d", rq, i), got, VEC[i][31:0]);
            end else begin
                bus_wr(VEC[i][43:32], VEC[i][31:0]);
            end
        end

        // R9 user 0 enabled on bit 2 which is set, user 1 has no enables
        chk("R9 irq combine", 32'(irq), 32'h1);
        bus_wr(12'h10C, 32'h4);
        chk("R9 irq off after enable clear", 32'(irq), 32'h0);
        bus_wr(12'h108, 32'h4);
        chk("R9 irq back on", 32'(irq), 32'h1);
        bus_rd(12'h044, got);
        chk("R2 pop FIFO 1", got, 32'hAA);
        bus_wr(12'h104, 32'h4);
        bus_rd(12'h104, got);
        chk("R6 clear once empty", got, 32'h0);
        chk("R9 irq low after clear", 32'(irq), 32'h0);

        // R7 not-full event of FIFO 2 routed to user 1 only
        bus_wr(12'h118, 32'h20);
        for (int k = 1; k <= 4; k++) bus_wr(12'h048, 32'(k));
        chk("R9 new-message not enabled on user 1", 32'(irq), 32'h0);
        bus_rd(12'h048, got);
        chk("R2 FIFO 2 head", got, 32'h1);
        chk("R7 not-full raises user 1", 32'(irq), 32'h2);

        // R10 write and read strobes together: only the write happens
        @(negedge clk);
        addr = 12'h048; wr_data = 32'h77; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        got = rd_data;
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R10 dual strobe read data", got, 32'h0);
        bus_rd(12'h0C8, got);
        chk("R10 dual strobe level", got, 32'd4);
        bus_rd(12'h048, got);
        chk("R2 order after dual strobe", got, 32'h2);

        // R11 reset while busy
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R11 irq after mid reset", 32'(irq), 32'h0);
        bus_rd(12'h0C8, got);
        chk("R11 level after mid reset", got, 32'h0);
        bus_rd(12'h114, got);
        chk("R11 status after mid reset", got, 32'h0);
        bus_rd(12'h118, got);
        chk("R11 enable after mid reset", got, 32'h0);
        bus_rd(12'h048, got);
        chk("R11 FIFO empty after mid reset", got, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule